// File: doc/BRIEF.md
# I/O Cycle Wait-State Controller

This block sits beside a microprocessor-style bus and turns the start of an I/O access into timed control strobes. When the address strobe is active and the status lines show an I/O data cycle, it raises a cycle-valid flag. It then drives either an active-low I/O read strobe or an active-low I/O write strobe, depending on the direction line. It counts wait states on a small counter and pulls an active-low ready for one clock once the count reaches the value programmed on a 3-bit select.

In a simple system the select is tied to the wait-state count of the slowest I/O device, so that every I/O access gets the same timing. One access is sequenced at a time. Memory cycles, control cycles and any further address strobes that arrive during an access leave the block untouched. All inputs are sampled on the rising clock edge, and reset is synchronous.

Top module: `io_wait_ctrl`

## Requirements
- R1: An access starts at a rising edge where the block is idle, `ads_n` is 0, `mio` is 0 (I/O) and `dc` is 1 (data). After that edge `cyc_valid` is 1 and `wcount` is 0.
- R2: While idle, no access starts at an edge where `ads_n` is 1, `mio` is 1 or `dc` is 0. `cyc_valid` stays 0, `rdy_n`, `ior_n` and `iow_n` stay 1, and `wcount` stays 0.
- R3: While `cyc_valid` is 1 and `rdy_n` is 1, `wcount` rises by exactly one on each clock. It never counts while idle.
- R4: An access sampled with `wr` = 0 drives `ior_n` low, and one sampled with `wr` = 1 drives `iow_n` low, from the start edge onward. Exactly one strobe is low while `cyc_valid` is 1, and neither is low while it is 0.
- R5: `rdy_n` is low exactly while `cyc_valid` is 1 and `wcount` equals the effective target. The target is `wait_sel`, or 1 when `wait_sel` is 0. A strobe therefore stays low for target+1 clocks, and `wcount` never exceeds the target.
- R6: `rdy_n` is low for exactly one clock. On the edge that follows, `cyc_valid` becomes 0, `wcount` becomes 0 and both strobes go high.
- R7: An address strobe sampled while `cyc_valid` is 1 is ignored, whatever its status lines show. The strobe already chosen and the count continue unchanged, and the ready timing is unchanged.
- R8: At an edge with `rst` = 1, `cyc_valid` and `wcount` clear and `ior_n` and `iow_n` go high. This applies in the middle of an access as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| mio | input | 1 | Access space: 1 memory, 0 I/O |
| dc | input | 1 | Cycle kind: 1 data, 0 control |
| wr | input | 1 | Direction: 1 write, 0 read |
| wait_sel | input | CNT_W | Programmed wait-state count (0 acts as 1) |
| cyc_valid | output | 1 | An I/O access is in progress |
| wcount | output | CNT_W | Wait-state counter value |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| rdy_n | output | 1 | Ready, active low, one clock per access |

## Verification
The bench builds the block with the default counter width of three bits. That width brings the whole select range within reach, from zero, which is folded to one, up to the full count of seven in which every counter bit toggles. Reads and writes are run at several select values, with the address strobe held through a busy access and with a reset in the middle of an access. A behavioural model is compared against all outputs on every clock.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;

  typedef struct packed {
    logic ads_n;
    logic mio;
    logic dc;
    logic wr;
  } bus_stat_t;

  // An I/O data cycle announced by the address strobe
  function automatic logic io_start_hit(input bus_stat_t s);
    return (!s.ads_n) && (!s.mio) && s.dc;
  endfunction

endpackage

// File: rtl/io_cycle_qual.sv
module io_cycle_qual
  import io_wait_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bus_stat_t stat,
  input  logic      done,
  output logic      cyc_valid,
  output logic      start
);

  logic valid_q;
  logic hit;

  assign hit       = io_start_hit(stat);
  assign start     = hit && !valid_q;
  assign cyc_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= 1'b0;
    else if (done)  valid_q <= 1'b0;
    else if (start) valid_q <= 1'b1;
  end

  // R1: a qualified strobe on an idle bus opens an access
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && hit) |=> valid_q);

  // R2: anything else keeps the block idle
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !hit) |=> !valid_q);

  // R7: a busy access is not disturbed before ready
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !done) |=> valid_q);

endmodule

// File: rtl/io_wait_counter.sv
module io_wait_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] carry;

  assign carry[0] = run;

  // Each bit toggles when every lower bit is set and the access is running
  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    if (i > 0) begin : g_chain
      assign carry[i] = carry[i-1] & count_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr)    count_q[i] <= 1'b0;
      else if (carry[i]) count_q[i] <= ~count_q[i];
    end
  end

  assign count = count_q;

  // R3: one step per clock while running
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !clr) |=> (count_q == $past(count_q) + 1'b1));

  // R3: frozen at zero while idle
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (count_q == '0));

endmodule

// File: rtl/io_ready_gen.sv
module io_ready_gen #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] sel,
  output logic             done,
  output logic             rdy_n
);

  // A select of zero still costs one wait state
  function automatic logic [CNT_W-1:0] wait_target(input logic [CNT_W-1:0] s);
    return (s == '0) ? CNT_W'(1) : s;
  endfunction

  logic [CNT_W-1:0] target;

  assign target = wait_target(sel);
  assign done   = run && (count == target);
  assign rdy_n  = !done;

  // R5: the counter never runs past the programmed target
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (count <= target));

  // R6: ready lasts a single clock
  p_one_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n) |=> rdy_n);

endmodule

// File: rtl/io_strobe_gen.sv
module io_strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_write,
  input  logic done,
  output logic rd_act,
  output logic wr_act
);

  logic rd_q;
  logic wr_q;

  // Set at the start edge, held until ready has been returned
  always_ff @(posedge clk) begin
    if (rst || done) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else if (start) begin
      rd_q <= !is_write;
      wr_q <= is_write;
    end
  end

  assign rd_act = rd_q;
  assign wr_act = wr_q;

  // R4: never both strobes
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_q, wr_q}));

  // R7: the chosen direction holds until ready
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((rd_q || wr_q) && !done) |=> ($stable(rd_q) && $stable(wr_q)));

endmodule

// File: rtl/io_wait_ctrl.sv
module io_wait_ctrl
  import io_wait_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ads_n,
  input  logic             mio,
  input  logic             dc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wait_sel,
  output logic             cyc_valid,
  output logic [CNT_W-1:0] wcount,
  output logic             ior_n,
  output logic             iow_n,
  output logic             rdy_n
);

  bus_stat_t        stat;
  logic             start;
  logic             done;
  logic             valid;
  logic [CNT_W-1:0] count;
  logic             rd_act;
  logic             wr_act;

  assign stat = '{ads_n: ads_n, mio: mio, dc: dc, wr: wr};

  io_cycle_qual u_qual (
    .clk      (clk),
    .rst      (rst),
    .stat     (stat),
    .done     (done),
    .cyc_valid(valid),
    .start    (start)
  );

  io_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (valid),
    .clr  (done),
    .count(count)
  );

  io_ready_gen #(.CNT_W(CNT_W)) u_rdy (
    .clk  (clk),
    .rst  (rst),
    .run  (valid),
    .count(count),
    .sel  (wait_sel),
    .done (done),
    .rdy_n(rdy_n)
  );

  io_strobe_gen u_strb (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .is_write(wr),
    .done    (done),
    .rd_act  (rd_act),
    .wr_act  (wr_act)
  );

  assign cyc_valid = valid;
  assign wcount    = count;
  assign ior_n     = !rd_act;
  assign iow_n     = !wr_act;

  // R4: one strobe exactly when an access is open
  p_strobe_match_r4: assert property (@(posedge clk) disable iff (rst)
    valid == ($countones({rd_act, wr_act}) == 1));

  // R1: a fresh access starts its count at zero
  p_start_zero_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == '0));

  // R6: everything clears on the edge after ready
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> (!valid && !rd_act && !wr_act && count == '0));

  // R8: synchronous reset clears the sequence
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!valid && !rd_act && !wr_act && count == '0));

endmodule

// File: tb/test_io_wait_ctrl.sv
module test_io_wait_ctrl;

  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ads_n = 1'b1;
  logic             mio = 1'b1;
  logic             dc = 1'b0;
  logic             wr = 1'b0;
  logic [CNT_W-1:0] wait_sel = '0;
  logic             cyc_valid;
  logic [CNT_W-1:0] wcount;
  logic             ior_n;
  logic             iow_n;
  logic             rdy_n;

  always #4 clk = ~clk;

  io_wait_ctrl #(.CNT_W(CNT_W)) i_io_wait_ctrl (
    .clk(clk), .rst(rst), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
    .wait_sel(wait_sel), .cyc_valid(cyc_valid), .wcount(wcount),
    .ior_n(ior_n), .iow_n(iow_n), .rdy_n(rdy_n)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    finished = 0;
  string cur_req = "R8";

  // Behavioural reference state
  int m_busy = 0, m_cnt = 0, m_rd = 0, m_wr = 0;

  function automatic int tgt(int s);
    return (s < 1) ? 1 : s;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_rd = 0; m_wr = 0;
    end else if (m_busy != 0) begin
      if (m_cnt == tgt(int'(wait_sel))) begin
        m_busy = 0; m_cnt = 0; m_rd = 0; m_wr = 0;
      end else begin
        m_cnt++;
      end
    end else if (!ads_n && !mio && dc) begin
      m_busy = 1; m_cnt = 0; m_rd = wr ? 0 : 1; m_wr = wr ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      int m_rdy;
      m_rdy = (m_busy != 0 && m_cnt == tgt(int'(wait_sel))) ? 1 : 0;
      chk(cur_req, "cyc_valid", int'(cyc_valid), m_busy);
      chk(cur_req, "wcount", int'(wcount), m_cnt);
      chk(cur_req, "ior_n", int'(ior_n), 1 - m_rd);
      chk(cur_req, "iow_n", int'(iow_n), 1 - m_wr);
      chk(cur_req, "rdy_n", int'(rdy_n), 1 - m_rdy);
    end
  end

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
      summary();
    end
  end

  // One I/O access; hold keeps the strobe low through the access with flipped direction
  task automatic access(string req, bit w, int sel, bit hold);
    int n;
    cur_req = req;
    @(posedge clk); #2;
    wait_sel = CNT_W'(sel); mio = 0; dc = 1; wr = w; ads_n = 0;
    @(posedge clk); #2;
    if (hold) wr = !w; else ads_n = 1;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if ((w ? iow_n : ior_n) == 1'b0) n++;
      if (!rdy_n) break;
    end
    #1 ads_n = 1;
    chk("R5", "strobe low clocks", n, tgt(sel) + 1);
    @(negedge clk);
    chk("R6", "valid after ready", int'(cyc_valid), 0);
    chk("R6", "strobes after ready", int'({ior_n, iow_n}), 3);
    chk("R6", "rdy_n after ready", int'(rdy_n), 1);
    @(posedge clk); #2;
    mio = 1; dc = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk("R8", "valid after reset", int'(cyc_valid), 0);

    // R2: non-qualifying status lines
    cur_req = "R2";
    ads_n = 0; mio = 1; dc = 1;
    repeat (2) @(posedge clk); #2;
    mio = 0; dc = 0;
    repeat (2) @(posedge clk); #2;
    ads_n = 1; dc = 1;
    repeat (2) @(posedge clk); #2;
    mio = 1; dc = 0;
    @(negedge clk);
    chk("R2", "no start", int'(cyc_valid), 0);

    // R1, R3, R4, R5 over reads and writes
    access("R1", 1'b0, 3, 1'b0);
    access("R4", 1'b1, 3, 1'b0);
    access("R5", 1'b0, 0, 1'b0);
    access("R5", 1'b1, 1, 1'b0);
    access("R3", 1'b0, 7, 1'b0);
    access("R3", 1'b1, 5, 1'b0);
    access("R4", 1'b1, 2, 1'b0);

    // R7: strobe held low through a busy access
    access("R7", 1'b0, 4, 1'b1);
    access("R7", 1'b1, 6, 1'b1);

    // R8: reset in the middle of an access
    cur_req = "R8";
    @(posedge clk); #2;
    wait_sel = 3'd6; mio = 0; dc = 1; wr = 0; ads_n = 0;
    @(posedge clk); #2;
    ads_n = 1;
    repeat (2) @(posedge clk); #2;
    rst = 1;
    @(posedge clk); #2;
    rst = 0;
    @(negedge clk);
    chk("R8", "valid after mid reset", int'(cyc_valid), 0);
    chk("R8", "count after mid reset", int'(wcount), 0);
    chk("R8", "ior_n after mid reset", int'(ior_n), 1);

    // R1: the block works again after the reset
    access("R1", 1'b1, 7, 1'b0);

    repeat (3) @(posedge clk);
    summary();
  end

endmodule